// File: doc/BRIEF.md
# Hex Record Emitter

This block turns a stream of addressed bytes into the printable text of a hexadecimal object file. Each input beat carries one data byte and its 32-bit byte address. The block gathers contiguous bytes into data records of up to `MAX_BYTES` bytes and writes each record as ASCII characters on an output stream. It inserts an upper-address record whenever the top half of the address differs from the last value it announced. A one-cycle `flush` pulse writes out any partly filled record and then the closing end-of-file line.

The record count is sent before the payload, so a record's bytes are held inside the block until the record is closed. A record closes when it is full, when the next presented address does not follow the previous one, when the low 16 address bits would wrap, or on flush. Both streams use valid/ready. On the input, `in_ready` is low while a record is being written out, while a flush is pending, and whenever the presented `in_addr` would break the current record. The producer must hold `in_valid`, `in_addr` and `in_data` until it sees `in_ready`. On the output, `out_char` and `out_valid` hold steady until `out_ready` is seen, and a character moves on each cycle where both are high. The consumer may stall for any number of cycles. `flush` is a plain pulse and is remembered until the end-of-file line has been fully accepted.

Top module: `hexemit_emitter`

## Requirements
- R1: Every record starts with ':' (0x3A). Every record byte is written as two uppercase hex digits (0-9 as 0x30-0x39, A-F as 0x41-0x46), high nibble first. Every line ends with CR (0x0D) then LF (0x0A).
- R2: A record's fields are written in this order: count byte, offset high byte, offset low byte, type byte, payload bytes, checksum byte. The checksum is the two's complement of the 8-bit sum of all earlier bytes in the record. Example: one byte 0xAB at offset 0x0010 gives ":01001000AB44".
- R3: A data record (type 0x00) holds at most `MAX_BYTES` bytes (16 by default). When the buffered record is full, it is written out without waiting for further input.
- R4: When the presented address is not the last accepted address plus one, the current record is closed and written with the bytes gathered so far. The new byte then starts the next record.
- R5: A record never spans a 64 KiB boundary. A byte whose low 16 address bits are 0x0000 never joins a record that began below it.
- R6: Before a data record whose upper 16 address bits differ from the last announced value, a type 0x04 record is written: count 0x02, offset 0x0000, upper bits MSB first. The announced value starts at zero, so data below 64 KiB gets no such record.
- R7: After a `flush` pulse, any buffered bytes are written as a data record, followed by ":00000001FF" and CR LF. After that line, the announced upper value returns to zero.
- R8: While `out_valid` is high and `out_ready` is low, `out_char` and `out_valid` stay unchanged. No character is lost or repeated under any stall pattern.
- R9: `in_ready` is low from the moment a record closes until its last character (and any end-of-file line) has been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Input beat accepted this cycle when high with `in_valid` |
| in_addr | input | 32 | Byte address of `in_data` |
| in_data | input | 8 | Data byte |
| flush | input | 1 | Pulse: write out pending bytes, then the end-of-file line |
| out_valid | output | 1 | Output character present |
| out_ready | input | 1 | Consumer takes `out_char` this cycle |
| out_char | output | 8 | ASCII character |

## Verification
A wrong buffer count or start address shows at the ports within one record. The count field, the offset digits or the checksum of the next emitted line will be wrong, and the line will appear before or after the byte where it should close. A stale announced upper value shows as a missing or extra type 0x04 line, directly in front of the next data record. A framer index or running-sum error corrupts the checksum digits, or moves the CR LF of the very line being written. Stall patterns on `out_ready` expose any character that is dropped or repeated, because the text stream no longer matches the expected one byte for byte.

// File: rtl/hexemit_pkg.sv
package hexemit_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_COLON,
    PH_HI,
    PH_LO,
    PH_CR,
    PH_LF
  } phase_t;

  typedef enum logic [1:0] {
    ST_COLLECT,
    ST_UPPER,
    ST_DATA,
    ST_CLOSE
  } state_t;

  localparam logic [7:0] REC_DATA  = 8'h00;
  localparam logic [7:0] REC_EOF   = 8'h01;
  localparam logic [7:0] REC_UPPER = 8'h04;

  localparam logic [7:0] CH_COLON = 8'h3A;
  localparam logic [7:0] CH_CR    = 8'h0D;
  localparam logic [7:0] CH_LF    = 8'h0A;

  // Maps a nibble to its uppercase ASCII hex digit.
  function automatic logic [7:0] nib_to_ascii(input logic [3:0] n);
    return (n < 4'd10) ? (8'h30 + {4'h0, n}) : (8'h37 + {4'h0, n});
  endfunction

endpackage

// File: rtl/hexemit_buffer.sv
module hexemit_buffer #(
  parameter int MAX_BYTES = 16
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                push,
  input  logic [31:0]                         push_addr,
  input  logic [7:0]                          push_data,
  input  logic                                clear,
  input  logic [7:0]                          rd_idx,
  output logic [7:0]                          rd_data,
  output logic [$clog2(MAX_BYTES+1)-1:0]      count,
  output logic [31:0]                         base_addr,
  output logic [31:0]                         next_addr
);
  localparam int CNT_W = $clog2(MAX_BYTES + 1);
  localparam int IDX_W = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1;
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(MAX_BYTES);
  localparam logic [7:0] MAX_IDX8 = 8'(MAX_BYTES);

  logic [7:0] mem [MAX_BYTES];

  always_ff @(posedge clk) begin
    if (push) mem[count[IDX_W-1:0]] <= push_data;
  end

  assign rd_data = (rd_idx < MAX_IDX8) ? mem[rd_idx[IDX_W-1:0]] : 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count     <= '0;
      base_addr <= '0;
      next_addr <= '0;
    end else if (clear) begin
      count <= '0;
    end else if (push) begin
      if (count == '0) base_addr <= push_addr;
      next_addr <= push_addr + 32'd1;
      count     <= count + 1'b1;
    end
  end

  // R3: occupancy never exceeds the record limit
  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT);
  // R3: no byte is written into a full record
  a_r3_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> count != FULL_CNT);
  // R4: bytes joining an open record follow the previous address
  a_r4_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
    (push && count != '0) |-> push_addr == next_addr);
  // R5: no open record is extended across a 64 KiB boundary
  a_r5_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (push && count != '0) |-> push_addr[15:0] != 16'h0000);

endmodule

// File: rtl/hexemit_framer.sv
module hexemit_framer
  import hexemit_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        go,
  input  logic [7:0]  rec_type,
  input  logic [7:0]  rec_count,
  input  logic [15:0] rec_offset,
  output logic [7:0]  pay_idx,
  input  logic [7:0]  pay_byte,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [7:0]  out_char,
  output logic        busy,
  output logic        done
);
  phase_t      phase;
  logic [8:0]  bidx;
  logic [7:0]  cnt_r;
  logic [15:0] off_r;
  logic [7:0]  typ_r;
  logic [7:0]  sum_r;
  logic [8:0]  last_idx;
  logic [8:0]  pay_idx9;
  logic [7:0]  cur_byte;
  logic        accept;

  assign last_idx = {1'b0, cnt_r} + 9'd4;
  assign pay_idx9 = bidx - 9'd4;
  assign pay_idx  = pay_idx9[7:0];

  always_comb begin
    if (bidx == 9'd0)           cur_byte = cnt_r;
    else if (bidx == 9'd1)      cur_byte = off_r[15:8];
    else if (bidx == 9'd2)      cur_byte = off_r[7:0];
    else if (bidx == 9'd3)      cur_byte = typ_r;
    else if (bidx == last_idx)  cur_byte = 8'h00 - sum_r;
    else                        cur_byte = pay_byte;
  end

  always_comb begin
    case (phase)
      PH_COLON: out_char = CH_COLON;
      PH_HI:    out_char = nib_to_ascii(cur_byte[7:4]);
      PH_LO:    out_char = nib_to_ascii(cur_byte[3:0]);
      PH_CR:    out_char = CH_CR;
      PH_LF:    out_char = CH_LF;
      default:  out_char = 8'h00;
    endcase
  end

  assign out_valid = (phase != PH_IDLE);
  assign busy      = out_valid;
  assign accept    = out_valid && out_ready;
  assign done      = accept && (phase == PH_LF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      bidx  <= '0;
      cnt_r <= '0;
      off_r <= '0;
      typ_r <= '0;
      sum_r <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (go) begin
          cnt_r <= rec_count;
          off_r <= rec_offset;
          typ_r <= rec_type;
          phase <= PH_COLON;
        end
        PH_COLON: if (accept) begin
          bidx  <= '0;
          sum_r <= '0;
          phase <= PH_HI;
        end
        PH_HI: if (accept) phase <= PH_LO;
        PH_LO: if (accept) begin
          sum_r <= sum_r + cur_byte;
          if (bidx == last_idx) phase <= PH_CR;
          else begin
            bidx  <= bidx + 9'd1;
            phase <= PH_HI;
          end
        end
        PH_CR: if (accept) phase <= PH_LF;
        PH_LF: if (accept) phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R8: an offered character is held until the consumer takes it
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_char)));

endmodule

// File: rtl/hexemit_emitter.sv
module hexemit_emitter
  import hexemit_pkg::*;
#(
  parameter int MAX_BYTES = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_addr,
  input  logic [7:0]  in_data,
  input  logic        flush,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [7:0]  out_char
);
  localparam int CNT_W = $clog2(MAX_BYTES + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(MAX_BYTES);

  state_t             state;
  logic [15:0]        last_upper;
  logic               flush_pend;
  logic [CNT_W-1:0]   buf_count;
  logic [31:0]        buf_base;
  logic [31:0]        buf_next;
  logic [7:0]         rd_data;
  logic [7:0]         pay_idx;
  logic [7:0]         pay_byte;
  logic [7:0]         rec_type;
  logic [7:0]         rec_count;
  logic [15:0]        rec_offset;
  logic               fr_busy;
  logic               fr_done;
  logic               buf_empty;
  logic               buf_full;
  logic               brk;
  logic               close_rec;
  logic               push;
  logic               clear;

  assign buf_empty = (buf_count == '0);
  assign buf_full  = (buf_count == FULL_CNT);
  assign brk       = !buf_empty &&
                     ((in_addr != buf_next) || (buf_next[15:0] == 16'h0000));
  assign in_ready  = (state == ST_COLLECT) && !flush_pend && !buf_full && !brk;
  assign push      = in_valid && in_ready;
  assign close_rec = (state == ST_COLLECT) && !buf_empty &&
                     (buf_full || flush_pend || (in_valid && brk));
  assign clear     = (state == ST_DATA) && fr_done;

  always_comb begin
    rec_type   = REC_EOF;
    rec_count  = 8'h00;
    rec_offset = 16'h0000;
    pay_byte   = 8'h00;
    case (state)
      ST_UPPER: begin
        rec_type  = REC_UPPER;
        rec_count = 8'h02;
        pay_byte  = (pay_idx == 8'h00) ? buf_base[31:24] : buf_base[23:16];
      end
      ST_DATA: begin
        rec_type   = REC_DATA;
        rec_count  = 8'(buf_count);
        rec_offset = buf_base[15:0];
        pay_byte   = rd_data;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_COLLECT;
      last_upper <= '0;
      flush_pend <= 1'b0;
    end else begin
      if ((state == ST_CLOSE) && fr_done) flush_pend <= 1'b0;
      else if (flush)                    flush_pend <= 1'b1;
      case (state)
        ST_COLLECT: begin
          if (close_rec)
            state <= (buf_base[31:16] != last_upper) ? ST_UPPER : ST_DATA;
          else if (flush_pend && buf_empty)
            state <= ST_CLOSE;
        end
        ST_UPPER: if (fr_done) begin
          last_upper <= buf_base[31:16];
          state      <= ST_DATA;
        end
        ST_DATA: if (fr_done) state <= ST_COLLECT;
        ST_CLOSE: if (fr_done) begin
          last_upper <= '0;
          state      <= ST_COLLECT;
        end
        default: state <= ST_COLLECT;
      endcase
    end
  end

  hexemit_buffer #(.MAX_BYTES(MAX_BYTES)) buf_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_addr (in_addr),
    .push_data (in_data),
    .clear     (clear),
    .rd_idx    (pay_idx),
    .rd_data   (rd_data),
    .count     (buf_count),
    .base_addr (buf_base),
    .next_addr (buf_next)
  );

  hexemit_framer framer_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (state != ST_COLLECT),
    .rec_type   (rec_type),
    .rec_count  (rec_count),
    .rec_offset (rec_offset),
    .pay_idx    (pay_idx),
    .pay_byte   (pay_byte),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_char   (out_char),
    .busy       (fr_busy),
    .done       (fr_done)
  );

  // R9: no input is taken while the framer is writing a line
  a_r9_quiet_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    fr_busy |-> !in_ready);
  // R6: a data record is only written once its upper bits are announced
  a_r6_upper_announced: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DATA) |-> (last_upper == buf_base[31:16]));

endmodule

// File: tb/hexemit_emitter_tb_top.sv
module hexemit_emitter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_addr = '0;
  logic [7:0]  in_data = '0;
  logic        flush = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [7:0]  out_char;

  always #5 clk = ~clk;

  hexemit_emitter #(.MAX_BYTES(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_data(in_data), .flush(flush),
    .out_valid(out_valid), .out_ready(out_ready), .out_char(out_char)
  );

  int tests = 0;
  int fails = 0;
  logic [7:0] exp_c [4096];
  logic [7:0] got_c [4096];
  int exp_n = 0;
  int got_n = 0;
  logic [7:0] pay [256];
  logic stall = 1'b0;
  int cyc = 0;
  logic hold_pend = 1'b0;
  logic [7:0] hold_c = '0;
  int hold_viol = 0;

  // Output sink: ready chosen at the falling edge, character taken there.
  always @(negedge clk) begin
    cyc = cyc + 1;
    out_ready = stall ? ((cyc % 3) != 1) : 1'b1;
    #1;
    if (hold_pend && (!out_valid || out_char != hold_c)) hold_viol = hold_viol + 1;
    hold_pend = out_valid && !out_ready;
    hold_c = out_char;
    if (out_valid && out_ready && got_n < 4096) begin
      got_c[got_n] = out_char;
      got_n = got_n + 1;
    end
  end

  task automatic check(input logic ok, input string tag, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  function automatic logic [7:0] hx(input logic [3:0] n);
    return (n < 4'd10) ? (8'h30 + {4'h0, n}) : (8'h37 + {4'h0, n});
  endfunction

  function automatic logic [7:0] dbyte(input logic [31:0] a);
    return 8'(a[7:0] * 8'd7 + a[15:8] + 8'd3);
  endfunction

  task automatic put_char(input logic [7:0] c);
    exp_c[exp_n] = c;
    exp_n++;
  endtask

  task automatic put_byte(input logic [7:0] b);
    put_char(hx(b[7:4]));
    put_char(hx(b[3:0]));
  endtask

  task automatic add_rec(input logic [7:0] typ, input logic [15:0] off, input int n);
    logic [7:0] s;
    s = 8'(n) + off[15:8] + off[7:0] + typ;
    put_char(8'h3A);
    put_byte(8'(n)); put_byte(off[15:8]); put_byte(off[7:0]); put_byte(typ);
    for (int i = 0; i < n; i++) begin
      put_byte(pay[i]);
      s = s + pay[i];
    end
    put_byte(8'h00 - s);
    put_char(8'h0D);
    put_char(8'h0A);
  endtask

  task automatic add_data(input logic [31:0] a, input int n);
    for (int i = 0; i < n; i++) pay[i] = dbyte(a + 32'(i));
    add_rec(8'h00, a[15:0], n);
  endtask

  task automatic add_upper(input logic [15:0] u);
    pay[0] = u[15:8];
    pay[1] = u[7:0];
    add_rec(8'h04, 16'h0000, 2);
  endtask

  task automatic add_eof();
    add_rec(8'h01, 16'h0000, 0);
  endtask

  task automatic send_byte(input logic [31:0] a);
    @(negedge clk);
    in_valid = 1'b1; in_addr = a; in_data = dbyte(a);
    #2;
    while (!in_ready) begin
      @(negedge clk);
      #2;
    end
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_run(input logic [31:0] a, input int n);
    for (int i = 0; i < n; i++) send_byte(a + 32'(i));
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic start_scn();
    exp_n = 0;
    got_n = 0;
  endtask

  task automatic drain_and_compare(input string tag);
    int t;
    int bad;
    t = 0;
    while (got_n < exp_n && t < 5000) begin
      @(negedge clk);
      t++;
    end
    repeat (40) @(negedge clk);
    check(got_n == exp_n, {tag, " char count"}, got_n, exp_n);
    bad = -1;
    for (int i = 0; i < exp_n && i < got_n; i++)
      if (bad < 0 && got_c[i] != exp_c[i]) bad = i;
    if (bad >= 0)
      check(1'b0, {tag, " char mismatch"}, got_c[bad], exp_c[bad]);
    else
      check(1'b1, tag, 0, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    #2;
    check(out_valid == 1'b0, "R8 reset out_valid", out_valid, 0);
    check(in_ready == 1'b1, "R9 reset in_ready", in_ready, 1);
  endtask

  task automatic t_full_record();
    start_scn();
    send_run(32'h0000_0100, 16);
    #2;
    check(in_ready == 1'b0, "R9 in_ready low after full", in_ready, 0);
    add_data(32'h0000_0100, 16);
    drain_and_compare("R3 R1 R6 full record before flush");
    send_run(32'h0000_0110, 3);
    do_flush();
    add_data(32'h0000_0110, 3);
    add_eof();
    drain_and_compare("R7 partial record then end line");
  endtask

  task automatic t_literal();
    string lit;
    int bad;
    start_scn();
    send_byte(32'h0000_0010);
    do_flush();
    lit = ":01001000";
    add_data(32'h0000_0010, 1);
    add_eof();
    drain_and_compare("R2 single byte record");
    bad = 0;
    for (int i = 0; i < 9; i++) if (got_c[i] != lit[i]) bad++;
    check(bad == 0, "R2 literal header", bad, 0);
  endtask

  task automatic t_checksum_literal();
    string lit;
    int bad;
    start_scn();
    lit = ":01001000AB44";
    @(negedge clk);
    in_valid = 1'b1; in_addr = 32'h0000_0010; in_data = 8'hAB;
    #2;
    while (!in_ready) begin @(negedge clk); #2; end
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    do_flush();
    pay[0] = 8'hAB;
    add_rec(8'h00, 16'h0010, 1);
    add_eof();
    drain_and_compare("R2 checksum stream");
    bad = 0;
    for (int i = 0; i < 13; i++) if (got_c[i] != lit[i]) bad++;
    check(bad == 0, "R2 checksum literal :01001000AB44", bad, 0);
  endtask

  task automatic t_discontig();
    start_scn();
    send_run(32'h0000_0200, 5);
    @(negedge clk);
    in_valid = 1'b1; in_addr = 32'h0000_0300; in_data = dbyte(32'h0000_0300);
    #2;
    check(in_ready == 1'b0, "R4 in_ready low on address gap", in_ready, 0);
    @(negedge clk);
    in_valid = 1'b0;
    send_byte(32'h0000_0300);
    do_flush();
    add_data(32'h0000_0200, 5);
    add_data(32'h0000_0300, 1);
    add_eof();
    drain_and_compare("R4 gap closes record");
  endtask

  task automatic t_boundary();
    start_scn();
    send_run(32'h0001_FFFE, 4);
    do_flush();
    add_upper(16'h0001);
    add_data(32'h0001_FFFE, 2);
    add_upper(16'h0002);
    add_data(32'h0002_0000, 2);
    add_eof();
    drain_and_compare("R5 R6 64KiB boundary split");
  endtask

  task automatic t_upper_reset();
    start_scn();
    send_byte(32'h0005_0010);
    do_flush();
    add_upper(16'h0005);
    add_data(32'h0005_0010, 1);
    add_eof();
    send_byte(32'h0005_0020);
    do_flush();
    add_upper(16'h0005);
    add_data(32'h0005_0020, 1);
    add_eof();
    drain_and_compare("R7 R6 upper value restarts at zero");
  endtask

  task automatic t_backpressure();
    start_scn();
    stall = 1'b1;
    hold_viol = 0;
    send_run(32'h0000_0400, 20);
    do_flush();
    add_data(32'h0000_0400, 16);
    add_data(32'h0000_0410, 4);
    add_eof();
    drain_and_compare("R8 stream under stalls");
    check(hold_viol == 0, "R8 char held while stalled", hold_viol, 0);
    stall = 1'b0;
  endtask

  task automatic t_flush_empty();
    string lit;
    int bad;
    start_scn();
    do_flush();
    add_eof();
    drain_and_compare("R7 flush with no data");
    lit = ":00000001FF";
    bad = 0;
    for (int i = 0; i < 11; i++) if (got_c[i] != lit[i]) bad++;
    check(bad == 0, "R7 end line literal", bad, 0);
    check(got_c[11] == 8'h0D && got_c[12] == 8'h0A, "R1 CR LF ending",
          {got_c[11], got_c[12]}, 16'h0D0A);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_full_record();
    t_literal();
    t_checksum_literal();
    t_discontig();
    t_boundary();
    t_upper_reset();
    t_backpressure();
    t_flush_empty();
    finish_run();
  end

endmodule